// File: doc/BRIEF.md
# Serial Port Bit-Clock Generator

This block produces the bit clock and the edge timing references for a synchronous serial port. It picks a divider source: either an internal tick that occurs once every six system-clock cycles, or the rising edges of an external clock input after they are synchronised into the system-clock domain. It then divides that source by an 8-bit divisor. The lengths of the high and low phases follow a fixed rule for even and odd divisors. The generated clock is driven to the transmit and receive clock outputs, and each output has its own polarity control. One-cycle strobes mark the rising and falling edges of the transmit clock as it appears at the output.

The block also passes the two frame-sync signals through their polarity controls. It generates the output enable for the transmit data pin. When the delay option is on, the first bit of a word can receive an extra enable delay of six or twelve system-clock cycles. A divisor of zero is not a valid setting: the clock is then held high and an error flag is raised. Changes to the divisor and to the source selection are applied only at a rising edge of the generated clock, so no runt pulse can reach the output.

Top module: `bclk_gen`

## Requirements
- R1: With `src_int_i`=1 the divider counts one source period per 6 system-clock cycles. With `src_int_i`=0 it counts one source period per rising edge of `ext_clk_i`, after synchronisation.
- R2: For an even divisor G>0, the generated clock is high for G/2+1 source periods and low for G/2 source periods.
- R3: For an odd divisor G, the generated clock is high for (G+1)/2 source periods and low for (G+1)/2 source periods.
- R4: `tx_rise_o` and `tx_fall_o` are each one system-clock cycle wide. Each is asserted in the same cycle that `tx_clk_o` goes high or goes low, respectively, with the polarity already applied.
- R5: A polarity input at 1 inverts its signal. `tx_clk_pol_i` acts on `tx_clk_o` and moves the two strobes with it, `rx_clk_pol_i` acts on `rx_clk_o`, `tx_fs_pol_i` maps `tx_fs_i` to `tx_fs_o`, and `rx_fs_pol_i` maps `rx_fs_i` to `rx_fs_o`.
- R6: A divisor of 0 holds the generated clock high with no strobes, and `cfg_err_o` reads 1. A later nonzero divisor restores normal clocking and clears `cfg_err_o`.
- R7: A new divisor or source selection takes effect at the next rising edge of the generated clock. The high phase in progress and the low phase after it keep the old setting.
- R8: While reset is asserted, the generated clock is low, so `tx_clk_o` equals `tx_clk_pol_i`. Both strobes, `dx_oe_o` and `cfg_err_o` read 0. The first rising edge after reset produces no strobe, and the first strobe is the falling edge that ends the first high phase.
- R9: When `bit_start_i` is asserted with `first_bit_i`=1 and `dly_en_i`=1, `dx_oe_o` rises 7 cycles after the cycle of the pulse when `zero_dly_i`=0, and 13 cycles after it when `zero_dly_i`=1.
- R10: When `bit_start_i` is asserted with `dly_en_i`=0, or with `first_bit_i`=0, `dx_oe_o` rises in the next cycle.
- R11: When `tx_idle_i` is 1, `dx_oe_o` is 0 from the next cycle and any pending delay is cancelled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_clk_i | input | 1 | External divider source clock |
| src_int_i | input | 1 | Source select: 1 = internal /6 tick, 0 = external clock |
| div_i | input | 8 | Divisor value |
| tx_clk_pol_i | input | 1 | Transmit clock polarity |
| rx_clk_pol_i | input | 1 | Receive clock polarity |
| tx_fs_pol_i | input | 1 | Transmit frame-sync polarity |
| rx_fs_pol_i | input | 1 | Receive frame-sync polarity |
| tx_fs_i | input | 1 | Transmit frame sync, before polarity |
| rx_fs_i | input | 1 | Receive frame sync, before polarity |
| bit_start_i | input | 1 | One-cycle pulse at the start of each transmit bit |
| first_bit_i | input | 1 | Marks the bit as the first bit of a word |
| dly_en_i | input | 1 | Enables the extra first-bit enable delay |
| zero_dly_i | input | 1 | Frame mode with zero data delay (selects the long delay) |
| tx_idle_i | input | 1 | Transmitter idle; clears the output enable |
| tx_clk_o | output | 1 | Transmit bit clock |
| rx_clk_o | output | 1 | Receive bit clock |
| tx_fs_o | output | 1 | Transmit frame sync after polarity |
| rx_fs_o | output | 1 | Receive frame sync after polarity |
| tx_rise_o | output | 1 | Strobe on a rising edge of `tx_clk_o` |
| tx_fall_o | output | 1 | Strobe on a falling edge of `tx_clk_o` |
| dx_oe_o | output | 1 | Transmit data output enable |
| cfg_err_o | output | 1 | Divisor of zero in use |

## Verification
The phase widths are measured in system cycles between strobes for two even divisors (2 and 6), two odd divisors (1 and 5), and divisor 0. Together these separate the even rule from the odd rule and show the extra source period in the high phase for even divisors. The same measurement is repeated with a slow external clock, which distinguishes the internal source from the external one. It is also repeated with the transmit polarity inverted, which shows that the strobes follow the pin level rather than the internal clock. A divisor written in the middle of a high phase shows whether the update waits for the next rising edge. The enable-delay runs compare the first bit and a later bit with the delay option on and off, and in both frame modes.

// File: rtl/bclk_pkg.sv
package bclk_pkg;
  localparam int unsigned DIV_W_DEF   = 8;
  localparam int unsigned PRE_DIV_DEF = 6;
  localparam int unsigned DLY_S_DEF   = 6;
  localparam int unsigned DLY_L_DEF   = 12;

  // source periods spent high / low for divisor g
  function automatic int unsigned hi_periods(int unsigned g);
    return (g % 2 == 0) ? g / 2 + 1 : (g + 1) / 2;
  endfunction

  function automatic int unsigned lo_periods(int unsigned g);
    return (g % 2 == 0) ? g / 2 : (g + 1) / 2;
  endfunction
endpackage

// File: rtl/bclk_src.sv
module bclk_src #(
  parameter int unsigned PRE_DIV     = bclk_pkg::PRE_DIV_DEF,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  output logic int_tick_o,
  output logic ext_tick_o
);
  localparam int unsigned PRE_W = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRE_DIV - 1);

  logic [PRE_W-1:0]       pre_q;
  logic [SYNC_STAGES:0]   sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pre_q <= '0;
    else if (pre_q == PRE_LAST) pre_q <= '0;
    else                       pre_q <= pre_q + 1'b1;
  end

  assign int_tick_o = (pre_q == PRE_LAST);

  // synchroniser plus one history stage for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign ext_tick_o = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

  // R1: internal tick is isolated, one per prescale period
  a_r1_int_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_tick_o |=> !int_tick_o);
  a_r1_ext_tick_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_tick_o |=> !ext_tick_o);
endmodule

// File: rtl/bclk_div.sv
module bclk_div #(
  parameter int unsigned DIV_W = bclk_pkg::DIV_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             int_tick_i,
  input  logic             ext_tick_i,
  input  logic             src_int_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             raw_o,
  output logic             rise_o,
  output logic             fall_o,
  output logic             cfg_err_o
);
  localparam int unsigned CNT_W = DIV_W;

  logic             started_q, started_d;
  logic             raw_q, raw_d;
  logic             sel_q, sel_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic             rise_q, rise_d, fall_q, fall_d;
  logic             sel_eff, tick;
  logic [CNT_W-1:0] hi_len, lo_len;

  assign sel_eff = started_q ? sel_q : src_int_i;
  assign tick    = sel_eff ? int_tick_i : ext_tick_i;
  assign hi_len  = CNT_W'(bclk_pkg::hi_periods(int'(div_q)));
  assign lo_len  = CNT_W'(bclk_pkg::lo_periods(int'(div_q)));
  assign cnt_inc = cnt_q + 1'b1;

  always_comb begin
    started_d = started_q;
    raw_d     = raw_q;
    sel_d     = sel_q;
    div_d     = div_q;
    cnt_d     = cnt_q;
    rise_d    = 1'b0;
    fall_d    = 1'b0;
    if (tick) begin
      if (!started_q) begin
        // first rise after reset: no strobe
        started_d = 1'b1;
        raw_d     = 1'b1;
        cnt_d     = '0;
        div_d     = div_i;
        sel_d     = src_int_i;
      end else if (raw_q) begin
        if (cnt_inc == hi_len) begin
          cnt_d = '0;
          if (lo_len == '0) begin
            // divisor 0: stay high, keep sampling config
            div_d = div_i;
            sel_d = src_int_i;
          end else begin
            raw_d  = 1'b0;
            fall_d = 1'b1;
          end
        end else begin
          cnt_d = cnt_inc;
        end
      end else begin
        if (cnt_inc == lo_len) begin
          cnt_d  = '0;
          raw_d  = 1'b1;
          rise_d = 1'b1;
          div_d  = div_i;
          sel_d  = src_int_i;
        end else begin
          cnt_d = cnt_inc;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      raw_q     <= 1'b0;
      sel_q     <= 1'b0;
      div_q     <= '0;
      cnt_q     <= '0;
      rise_q    <= 1'b0;
      fall_q    <= 1'b0;
    end else begin
      started_q <= started_d;
      raw_q     <= raw_d;
      sel_q     <= sel_d;
      div_q     <= div_d;
      cnt_q     <= cnt_d;
      rise_q    <= rise_d;
      fall_q    <= fall_d;
    end
  end

  assign raw_o     = raw_q;
  assign rise_o    = rise_q;
  assign fall_o    = fall_q;
  assign cfg_err_o = started_q && (div_q == '0);

  // R4: strobes coincide with a level change of the generated clock
  a_r4_rise_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_q |-> raw_q && !$past(raw_q));
  a_r4_fall_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_q |-> !raw_q && $past(raw_q));
  a_r4_strobe_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_q && fall_q));
  // R6: divisor 0 never leaves the high phase
  a_r6_zero_holds_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (started_q && raw_q && div_q == '0) |=> raw_q);
  // R7: configuration only reloads while the clock is high
  a_r7_cfg_at_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q != $past(div_q) || sel_q != $past(sel_q)) |-> raw_q);
  // R8: the first rise after reset carries no strobe
  a_r8_first_rise_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(started_q) |-> !rise_q && !fall_q);
endmodule

// File: rtl/bclk_oe_dly.sv
module bclk_oe_dly #(
  parameter int unsigned DLY_S = bclk_pkg::DLY_S_DEF,
  parameter int unsigned DLY_L = bclk_pkg::DLY_L_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bit_start_i,
  input  logic first_bit_i,
  input  logic dly_en_i,
  input  logic zero_dly_i,
  input  logic idle_i,
  output logic oe_o
);
  localparam int unsigned W = $clog2(DLY_L + 1);

  logic [W-1:0] cnt_q;
  logic         oe_q;
  logic         delayed;

  assign delayed = first_bit_i && dly_en_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (idle_i) begin
      cnt_q <= '0;
      oe_q  <= 1'b0;
    end else if (bit_start_i) begin
      if (delayed) begin
        cnt_q <= zero_dly_i ? W'(DLY_L) : W'(DLY_S);
        oe_q  <= 1'b0;
      end else begin
        cnt_q <= '0;
        oe_q  <= 1'b1;
      end
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == W'(1)) oe_q <= 1'b1;
    end
  end

  assign oe_o = oe_q;

  a_r9_first_bit_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_start_i && delayed && !idle_i) |=> !oe_o);
  a_r10_no_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_start_i && !delayed && !idle_i) |=> oe_o);
  a_r11_idle_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_i |=> !oe_o);
endmodule

// File: rtl/bclk_gen.sv
module bclk_gen #(
  parameter int unsigned DIV_W   = bclk_pkg::DIV_W_DEF,
  parameter int unsigned PRE_DIV = bclk_pkg::PRE_DIV_DEF,
  parameter int unsigned DLY_S   = bclk_pkg::DLY_S_DEF,
  parameter int unsigned DLY_L   = bclk_pkg::DLY_L_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_clk_i,
  input  logic             src_int_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tx_clk_pol_i,
  input  logic             rx_clk_pol_i,
  input  logic             tx_fs_pol_i,
  input  logic             rx_fs_pol_i,
  input  logic             tx_fs_i,
  input  logic             rx_fs_i,
  input  logic             bit_start_i,
  input  logic             first_bit_i,
  input  logic             dly_en_i,
  input  logic             zero_dly_i,
  input  logic             tx_idle_i,
  output logic             tx_clk_o,
  output logic             rx_clk_o,
  output logic             tx_fs_o,
  output logic             rx_fs_o,
  output logic             tx_rise_o,
  output logic             tx_fall_o,
  output logic             dx_oe_o,
  output logic             cfg_err_o
);
  logic int_tick, ext_tick;
  logic raw, raw_rise, raw_fall;

  bclk_src #(.PRE_DIV(PRE_DIV), .SYNC_STAGES(2)) u_src (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ext_clk_i  (ext_clk_i),
    .int_tick_o (int_tick),
    .ext_tick_o (ext_tick)
  );

  bclk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .int_tick_i (int_tick),
    .ext_tick_i (ext_tick),
    .src_int_i  (src_int_i),
    .div_i      (div_i),
    .raw_o      (raw),
    .rise_o     (raw_rise),
    .fall_o     (raw_fall),
    .cfg_err_o  (cfg_err_o)
  );

  bclk_oe_dly #(.DLY_S(DLY_S), .DLY_L(DLY_L)) u_oe (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bit_start_i (bit_start_i),
    .first_bit_i (first_bit_i),
    .dly_en_i    (dly_en_i),
    .zero_dly_i  (zero_dly_i),
    .idle_i      (tx_idle_i),
    .oe_o        (dx_oe_o)
  );

  // polarity: the reference edge swaps along with the level
  assign tx_clk_o  = raw ^ tx_clk_pol_i;
  assign rx_clk_o  = raw ^ rx_clk_pol_i;
  assign tx_fs_o   = tx_fs_i ^ tx_fs_pol_i;
  assign rx_fs_o   = rx_fs_i ^ rx_fs_pol_i;
  assign tx_rise_o = tx_clk_pol_i ? raw_fall : raw_rise;
  assign tx_fall_o = tx_clk_pol_i ? raw_rise : raw_fall;

  a_r5_rise_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rise_o |-> tx_clk_o);
  a_r5_fall_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fall_o |-> !tx_clk_o);
endmodule

// File: tb/bclk_gen_test.sv
module bclk_gen_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_clk_i = 1'b0;
  logic       src_int_i = 1'b1;
  logic [7:0] div_i = 8'd2;
  logic       tx_clk_pol_i = 1'b0, rx_clk_pol_i = 1'b0;
  logic       tx_fs_pol_i = 1'b0, rx_fs_pol_i = 1'b0;
  logic       tx_fs_i = 1'b0, rx_fs_i = 1'b0;
  logic       bit_start_i = 1'b0, first_bit_i = 1'b0;
  logic       dly_en_i = 1'b0, zero_dly_i = 1'b0, tx_idle_i = 1'b1;
  logic       tx_clk_o, rx_clk_o, tx_fs_o, rx_fs_o;
  logic       tx_rise_o, tx_fall_o, dx_oe_o, cfg_err_o;
  logic       ext_run = 1'b0;

  int n_run = 0;
  int n_fail = 0;

  bclk_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_clk_i(ext_clk_i), .src_int_i(src_int_i),
    .div_i(div_i), .tx_clk_pol_i(tx_clk_pol_i), .rx_clk_pol_i(rx_clk_pol_i),
    .tx_fs_pol_i(tx_fs_pol_i), .rx_fs_pol_i(rx_fs_pol_i), .tx_fs_i(tx_fs_i),
    .rx_fs_i(rx_fs_i), .bit_start_i(bit_start_i), .first_bit_i(first_bit_i),
    .dly_en_i(dly_en_i), .zero_dly_i(zero_dly_i), .tx_idle_i(tx_idle_i),
    .tx_clk_o(tx_clk_o), .rx_clk_o(rx_clk_o), .tx_fs_o(tx_fs_o), .rx_fs_o(rx_fs_o),
    .tx_rise_o(tx_rise_o), .tx_fall_o(tx_fall_o), .dx_oe_o(dx_oe_o),
    .cfg_err_o(cfg_err_o)
  );

  always #5 clk_i = ~clk_i;

  // external source: toggles every 5 system cycles -> period 10
  initial begin
    forever begin
      repeat (5) @(negedge clk_i);
      if (ext_run) ext_clk_i = ~ext_clk_i;
    end
  end

  initial begin
    #3_000_000;
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete act=%0d exp=%0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rise();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk_i);
      if (tx_rise_o) break;
    end
  endtask

  // returns high and low widths in system cycles, from strobe to strobe
  task automatic measure(output int hi, output int lo);
    wait_rise();
    chk("R4 level at rise strobe", int'(tx_clk_o), 1);
    hi = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk_i);
      hi++;
      if (hi == 1) chk("R4 rise strobe width", int'(tx_rise_o), 0);
      if (tx_fall_o) break;
    end
    chk("R4 level at fall strobe", int'(tx_clk_o), 0);
    lo = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk_i);
      lo++;
      if (tx_rise_o) break;
    end
  endtask

  // apply a setting, skip one period to settle, measure the next
  task automatic run_cfg(output int hi, output int lo);
    int h0, l0;
    measure(h0, l0);
    measure(hi, lo);
  endtask

  task automatic t_reset();
    int rises = 0, saw_high = 0, fell = 0;
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    chk("R8 clock low in reset", int'(tx_clk_o), 0);
    chk("R8 rise strobe in reset", int'(tx_rise_o), 0);
    chk("R8 fall strobe in reset", int'(tx_fall_o), 0);
    chk("R8 oe in reset", int'(dx_oe_o), 0);
    chk("R8 cfg_err in reset", int'(cfg_err_o), 0);
    rst_ni = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      if (tx_rise_o) rises++;
      if (tx_clk_o) saw_high = 1;
      if (tx_fall_o) begin fell = 1; break; end
    end
    chk("R8 no strobe on first rise", rises, 0);
    chk("R8 clock went high", saw_high, 1);
    chk("R8 first strobe is fall", fell, 1);
  endtask

  task automatic t_even();
    int hi, lo;
    div_i = 8'd2; run_cfg(hi, lo);
    chk("R2 G=2 high", hi, 12); chk("R2 G=2 low", lo, 6);
    div_i = 8'd6; run_cfg(hi, lo);
    chk("R2 G=6 high", hi, 24); chk("R2 G=6 low", lo, 18);
  endtask

  task automatic t_odd();
    int hi, lo;
    div_i = 8'd5; run_cfg(hi, lo);
    chk("R3 G=5 high", hi, 18); chk("R3 G=5 low", lo, 18);
    div_i = 8'd1; run_cfg(hi, lo);
    chk("R3 R1 G=1 high", hi, 6); chk("R3 R1 G=1 low", lo, 6);
  endtask

  task automatic t_change();
    int hi, lo, n;
    div_i = 8'd4; run_cfg(hi, lo);
    wait_rise();
    n = 0;
    repeat (3) begin @(negedge clk_i); n++; end
    div_i = 8'd7;
    for (int i = 0; i < 1000; i++) begin
      if (tx_fall_o) break;
      @(negedge clk_i); n++;
    end
    chk("R7 current high keeps old divisor", n, 18);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk_i); n++;
      if (tx_rise_o) break;
    end
    chk("R7 following low keeps old divisor", n, 12);
    n = 0;
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk_i); n++;
      if (tx_fall_o) break;
    end
    chk("R7 next high uses new divisor", n, 24);
  endtask

  task automatic t_ext();
    int hi, lo;
    ext_run = 1'b1;
    src_int_i = 1'b0; div_i = 8'd3;
    run_cfg(hi, lo);
    chk("R1 external G=3 high", hi, 20); chk("R1 external G=3 low", lo, 20);
    src_int_i = 1'b1;
    run_cfg(hi, lo);
    chk("R1 back to internal high", hi, 12); chk("R1 back to internal low", lo, 12);
    ext_run = 1'b0;
  endtask

  task automatic t_pol();
    int hi, lo;
    div_i = 8'd2;
    tx_clk_pol_i = 1'b1;
    run_cfg(hi, lo);
    chk("R5 inverted high", hi, 6); chk("R5 inverted low", lo, 12);
    @(negedge clk_i);
    chk("R5 rx clock uninverted", int'(rx_clk_o), int'(!tx_clk_o));
    rx_clk_pol_i = 1'b1;
    @(negedge clk_i);
    chk("R5 rx clock inverted", int'(rx_clk_o), int'(tx_clk_o));
    tx_clk_pol_i = 1'b0; rx_clk_pol_i = 1'b0;
    tx_fs_i = 1'b1; rx_fs_i = 1'b0; tx_fs_pol_i = 1'b1; rx_fs_pol_i = 1'b1;
    @(negedge clk_i);
    chk("R5 tx fs inverted", int'(tx_fs_o), 0);
    chk("R5 rx fs inverted", int'(rx_fs_o), 1);
    tx_fs_pol_i = 1'b0; rx_fs_pol_i = 1'b0;
    @(negedge clk_i);
    chk("R5 tx fs passed", int'(tx_fs_o), 1);
    chk("R5 rx fs passed", int'(rx_fs_o), 0);
  endtask

  task automatic t_zero();
    int hi, lo, strobes = 0, lows = 0;
    div_i = 8'd0;
    repeat (40) @(negedge clk_i);
    for (int i = 0; i < 120; i++) begin
      @(negedge clk_i);
      if (tx_rise_o || tx_fall_o) strobes++;
      if (!tx_clk_o) lows++;
    end
    chk("R6 no strobes with G=0", strobes, 0);
    chk("R6 held high with G=0", lows, 0);
    chk("R6 cfg_err set", int'(cfg_err_o), 1);
    div_i = 8'd2;
    run_cfg(hi, lo);
    chk("R6 recovered high", hi, 12); chk("R6 recovered low", lo, 6);
    chk("R6 cfg_err cleared", int'(cfg_err_o), 0);
  endtask

  task automatic oe_lat(input logic first, input logic en, input logic zero, output int n);
    tx_idle_i = 1'b1;
    @(negedge clk_i);
    tx_idle_i = 1'b0; first_bit_i = first; dly_en_i = en; zero_dly_i = zero;
    bit_start_i = 1'b1;
    @(negedge clk_i);
    bit_start_i = 1'b0;
    n = 1;
    for (int i = 0; i < 50; i++) begin
      if (dx_oe_o) break;
      @(negedge clk_i); n++;
    end
  endtask

  task automatic t_oe();
    int n;
    oe_lat(1'b1, 1'b0, 1'b0, n); chk("R10 first bit, delay off", n, 1);
    oe_lat(1'b0, 1'b1, 1'b0, n); chk("R10 later bit, delay on", n, 1);
    oe_lat(1'b1, 1'b1, 1'b0, n); chk("R9 first bit short delay", n, 7);
    oe_lat(1'b1, 1'b1, 1'b1, n); chk("R9 first bit long delay", n, 13);
    tx_idle_i = 1'b1;
    @(negedge clk_i);
    chk("R11 idle clears oe", int'(dx_oe_o), 0);
    oe_lat(1'b1, 1'b1, 1'b0, n);
    tx_idle_i = 1'b1;
    tx_idle_i = 1'b0;
    // idle in mid-delay cancels pending enable
    tx_idle_i = 1'b1;
    @(negedge clk_i);
    tx_idle_i = 1'b0; first_bit_i = 1'b1; dly_en_i = 1'b1; zero_dly_i = 1'b0;
    bit_start_i = 1'b1;
    @(negedge clk_i);
    bit_start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    tx_idle_i = 1'b1;
    @(negedge clk_i);
    tx_idle_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk("R11 idle cancels pending delay", int'(dx_oe_o), 0);
  endtask

  initial begin
    t_reset();
    t_even();
    t_odd();
    t_change();
    t_ext();
    t_pol();
    t_zero();
    t_oe();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule